// File: doc/BRIEF.md
# Three-Leg Gate Sequencer with Dead Time and Synchronous Rectification

This block turns per-leg phase requests into high-side and low-side gate commands for three half-bridges. Each leg takes a two-bit request that asks for the upper transistor, the lower transistor, or neither. A direction input swaps upper and lower across all legs. While the PWM input is low, the decay-select input picks which transistor carries the recirculating current, and the block turns that transistor on so the current does not flow through its body diode. A bootstrap-charge request drives every lower transistor on, and a coast input drops every gate at once.

Each leg runs its own state machine with states OFF, DEAD, HIGH_ON and LOW_ON. OFF moves to DEAD when the leg's target side becomes high or low. HIGH_ON and LOW_ON move to DEAD as soon as the target differs from the side that is on. DEAD holds both gates low for the programmed dead count and then moves to HIGH_ON, LOW_ON or OFF, whichever the target is at that moment. Coast forces every machine to OFF. The dead count is a clock-cycle count presented on an input. It is captured each time a leg enters DEAD and covers the 100 ns to 5.5 µs range at common system clock rates.

Top module: `srdt_sequencer`

## Requirements
- R1: In no cycle are the high-side and low-side gate outputs of one leg both 1.
- R2: When a leg changes side, the old gate drops in the cycle after the changed inputs are sampled. The new gate rises exactly D cycles later, where D is the dead count. Every gate rise follows at least D cycles with both gates of that leg low.
- R3: A dead count of 0 acts as a dead count of 1.
- R4: Leg n reads request bits [2n+1:2n]. 01 asks for the high side and 10 asks for the low side. 00 and 11 ask for neither. With PWM high, direction 0 and no bootstrap request, the leg settles to the requested gate.
- R5: With direction 1, high and low requests are swapped before any other rule is applied.
- R6: With PWM low and decay select 0, a leg whose target is the high side drives the low side instead. A leg whose target is the low side keeps it.
- R7: With PWM low and decay select 1, a leg whose target is the low side drives the high side instead. A leg whose target is the high side keeps it.
- R8: A bootstrap-charge request drives every leg to the low side. This includes legs requesting neither, and it takes priority over PWM, decay select and direction.
- R9: Coast forces all gates to 0 in the same cycle and returns every leg to OFF. After coast is released, no gate rises until a full dead count has passed.
- R10: After reset, all gate outputs are 0.
- R11: A leg requesting neither side stays off whatever the PWM level and decay select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coast_i | input | 1 | Forces all gates low immediately |
| phase_req_i | input | 2*N_LEGS | Per-leg side request, two bits per leg |
| pwm_i | input | 1 | PWM on (1) or recirculation interval (0) |
| decay_sel_i | input | 1 | 0: low-side recirculation, 1: high-side recirculation |
| dir_i | input | 1 | 1 swaps high and low requests |
| boot_req_i | input | 1 | Bootstrap charge: all low sides on |
| dead_cycles_i | input | DT_W | Dead time in clock cycles |
| gate_hi_o | output | N_LEGS | High-side gate commands |
| gate_lo_o | output | N_LEGS | Low-side gate commands |

## Verification
The gap assertion compares a leg's gate rise against the dead count captured when that leg entered DEAD. It therefore assumes the dead-count input is a configuration value that does not need to match at the moment of the rise. The bench changes the dead count only while all legs are steady, so its own gap monitor can use the current value. Requests, PWM and mode are treated as synchronous inputs, and the bench changes them just after falling edges. Coast is assumed to be held for at least one rising edge so that the machines reach OFF.

// File: rtl/srdt_pkg.sv
package srdt_pkg;
    // Side a leg is asked to conduct on
    typedef enum logic [1:0] {
        SIDE_OFF = 2'd0,
        SIDE_HI  = 2'd1,
        SIDE_LO  = 2'd2
    } side_t;

    // Per-leg sequencer state
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_DEAD    = 2'd1,
        ST_HIGH_ON = 2'd2,
        ST_LOW_ON  = 2'd3
    } leg_st_t;

    // Request encodings on the two-bit phase field
    localparam logic [1:0] REQ_HI = 2'b01;
    localparam logic [1:0] REQ_LO = 2'b10;
endpackage

// File: rtl/srdt_target.sv
module srdt_target
    import srdt_pkg::*;
(
    input  logic [1:0] req_i,
    input  logic       pwm_i,
    input  logic       decay_sel_i,
    input  logic       dir_i,
    input  logic       boot_req_i,
    output side_t      tgt_o
);
    side_t raw_side;
    side_t dir_side;

    // Decode the request field
    always_comb begin
        unique case (req_i)
            REQ_HI:  raw_side = SIDE_HI;
            REQ_LO:  raw_side = SIDE_LO;
            default: raw_side = SIDE_OFF;
        endcase
    end

    // Direction reversal swaps the two sides (R5)
    always_comb begin
        dir_side = raw_side;
        if (dir_i) begin
            unique case (raw_side)
                SIDE_HI: dir_side = SIDE_LO;
                SIDE_LO: dir_side = SIDE_HI;
                default: dir_side = SIDE_OFF;
            endcase
        end
    end

    // Bootstrap priority, then synchronous rectification in the off-time
    always_comb begin
        tgt_o = dir_side;
        if (boot_req_i) begin
            tgt_o = SIDE_LO;
        end else if (!pwm_i) begin
            if (!decay_sel_i && dir_side == SIDE_HI) begin
                tgt_o = SIDE_LO;
            end else if (decay_sel_i && dir_side == SIDE_LO) begin
                tgt_o = SIDE_HI;
            end
        end
    end
endmodule

// File: rtl/srdt_leg_fsm.sv
module srdt_leg_fsm
    import srdt_pkg::*;
#(
    parameter int DT_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            coast_i,
    input  side_t           tgt_i,
    input  logic [DT_W-1:0] dead_cycles_i,
    output logic            gate_hi_o,
    output logic            gate_lo_o
);
    localparam int RUN_W = DT_W + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    leg_st_t         state_q, state_d;
    logic [DT_W-1:0] cnt_q;
    logic [DT_W-1:0] dead_lat_q;
    logic [DT_W-1:0] dead_eff;
    logic            enter_dead;

    // Zero is clamped to one cycle (R3)
    assign dead_eff   = (dead_cycles_i == '0) ? {{(DT_W-1){1'b0}}, 1'b1} : dead_cycles_i;
    assign enter_dead = (state_q != ST_DEAD) && (state_d == ST_DEAD);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (tgt_i != SIDE_OFF) state_d = ST_DEAD;
            end
            ST_DEAD: begin
                if (cnt_q == '0) begin
                    unique case (tgt_i)
                        SIDE_HI: state_d = ST_HIGH_ON;
                        SIDE_LO: state_d = ST_LOW_ON;
                        default: state_d = ST_OFF;
                    endcase
                end
            end
            ST_HIGH_ON: begin
                if (tgt_i != SIDE_HI) state_d = ST_DEAD;
            end
            ST_LOW_ON: begin
                if (tgt_i != SIDE_LO) state_d = ST_DEAD;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register and dead counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_OFF;
            cnt_q      <= '0;
            dead_lat_q <= {{(DT_W-1){1'b0}}, 1'b1};
        end else if (coast_i) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (enter_dead) begin
                cnt_q      <= dead_eff - 1'b1;
                dead_lat_q <= dead_eff;
            end else if (state_q == ST_DEAD && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Gate outputs: coast acts without waiting for a clock edge
    always_comb begin
        gate_hi_o = 1'b0;
        gate_lo_o = 1'b0;
        unique case (state_q)
            ST_HIGH_ON: gate_hi_o = !coast_i;
            ST_LOW_ON:  gate_lo_o = !coast_i;
            default: ;
        endcase
    end

    // Checker counter: consecutive cycles with both gates low
    logic [RUN_W-1:0] off_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run_q <= '0;
        end else if (gate_hi_o || gate_lo_o) begin
            off_run_q <= '0;
        end else if (off_run_q != RUN_MAX) begin
            off_run_q <= off_run_q + 1'b1;
        end
    end

    p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_o && gate_lo_o));

    p_dead_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi_o) || $rose(gate_lo_o)) |-> (off_run_q >= {1'b0, dead_lat_q}));

    p_coast_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        coast_i |=> (!gate_hi_o && !gate_lo_o));
endmodule

// File: rtl/srdt_sequencer.sv
module srdt_sequencer
    import srdt_pkg::*;
#(
    parameter int N_LEGS = 3,
    parameter int DT_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  coast_i,
    input  logic [2*N_LEGS-1:0]   phase_req_i,
    input  logic                  pwm_i,
    input  logic                  decay_sel_i,
    input  logic                  dir_i,
    input  logic                  boot_req_i,
    input  logic [DT_W-1:0]       dead_cycles_i,
    output logic [N_LEGS-1:0]     gate_hi_o,
    output logic [N_LEGS-1:0]     gate_lo_o
);
    side_t leg_tgt [N_LEGS];

    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        srdt_target u_tgt (
            .req_i       (phase_req_i[2*g +: 2]),
            .pwm_i       (pwm_i),
            .decay_sel_i (decay_sel_i),
            .dir_i       (dir_i),
            .boot_req_i  (boot_req_i),
            .tgt_o       (leg_tgt[g])
        );

        srdt_leg_fsm #(.DT_W(DT_W)) u_fsm (
            .clk           (clk),
            .rst_n         (rst_n),
            .coast_i       (coast_i),
            .tgt_i         (leg_tgt[g]),
            .dead_cycles_i (dead_cycles_i),
            .gate_hi_o     (gate_hi_o[g]),
            .gate_lo_o     (gate_lo_o[g])
        );

        // A gate only rises toward the side the decoder asked for (R4)
        p_hi_follows_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi_o[g]) |-> $past(leg_tgt[g] == SIDE_HI));

        p_lo_follows_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_lo_o[g]) |-> $past(leg_tgt[g] == SIDE_LO));
    end
endmodule

// File: tb/srdt_sequencer_tb_top.sv
module srdt_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DT_W       = 12;
    localparam int LEGS       = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            coast = 1'b0;
    logic [5:0]      req = '0;
    logic            pwm = 1'b1;
    logic            mode = 1'b0;
    logic            dir = 1'b0;
    logic            boot = 1'b0;
    logic [DT_W-1:0] dead = 12'd4;
    logic [2:0]      gh, gl;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srdt_sequencer #(.N_LEGS(LEGS), .DT_W(DT_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .coast_i       (coast),
        .phase_req_i   (req),
        .pwm_i         (pwm),
        .decay_sel_i   (mode),
        .dir_i         (dir),
        .boot_req_i    (boot),
        .dead_cycles_i (dead),
        .gate_hi_o     (gh),
        .gate_lo_o     (gl)
    );

    typedef struct {
        logic [2:0] hi;
        logic [2:0] lo;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // Scoreboard monitor: one expected item per falling edge
    always @(negedge clk) begin
        exp_t e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (gh !== e.hi || gl !== e.lo) begin
                errors++;
                $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", e.tag, gh, gl, e.hi, e.lo);
            end
        end
    end

    // Independent gap and overlap monitor (R1, R2)
    int         off_run [LEGS];
    logic [2:0] prev_on = '0;
    always @(negedge clk) begin
        int need;
        need = (dead == '0) ? 1 : int'(dead);
        for (int i = 0; i < LEGS; i++) begin
            if (!rst_n) begin
                off_run[i] = 0;
            end else begin
                if (gh[i] && gl[i]) begin
                    errors++;
                    $display("FAIL R1 leg %0d: hi=1 lo=1 expected not both", i);
                end
                if ((gh[i] || gl[i]) && !prev_on[i]) begin
                    checks++;
                    if (off_run[i] < need) begin
                        errors++;
                        $display("FAIL R2 leg %0d gap: %0d expected >= %0d", i, off_run[i], need);
                    end
                end
                if (gh[i] || gl[i]) off_run[i] = 0;
                else off_run[i] = off_run[i] + 1;
            end
            prev_on[i] = gh[i] || gl[i];
        end
    end

    // Expected gate pair from the requirements: returns {hi, lo}
    function automatic logic [1:0] leg_model(input logic [1:0] r, input logic p,
                                             input logic m, input logic d, input logic b);
        logic [1:0] s;
        s = (r == 2'b01 || r == 2'b10) ? r : 2'b00;
        if (d && s != 2'b00) s = ~s;
        if (b) s = 2'b10;
        else if (!p) begin
            if (!m && s == 2'b01) s = 2'b10;
            else if (m && s == 2'b10) s = 2'b01;
        end
        return {s == 2'b01, s == 2'b10};
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic expect_next(input logic [2:0] hi, input logic [2:0] lo, input string tag);
        exp_t e;
        e.hi = hi;
        e.lo = lo;
        e.tag = tag;
        sb_q.push_back(e);
        step();
    endtask

    task automatic expect_model(input string tag);
        logic [2:0] hi, lo;
        logic [1:0] pr;
        int         n;
        n = ((dead == '0) ? 1 : int'(dead)) + 3;
        repeat (n) step();
        for (int i = 0; i < LEGS; i++) begin
            pr = leg_model(req[2*i +: 2], pwm, mode, dir, boot);
            hi[i] = pr[1];
            lo[i] = pr[0];
        end
        expect_next(hi, lo, tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        expect_next(3'b000, 3'b000, "R10 reset state");

        // R4: leg0 high, leg1 low, leg2 off
        req = 6'b00_10_01;
        expect_model("R4 plain request");

        // R2: exact dead timing, legs 0 and 1 swap sides with D=4
        req = 6'b00_01_10;
        for (int k = 0; k < 4; k++) expect_next(3'b000, 3'b000, "R2 dead interval D=4");
        expect_next(3'b010, 3'b001, "R2 turn-on after D=4");

        // R6 and R11: low-side recirculation
        pwm = 1'b0;
        mode = 1'b0;
        expect_model("R6 low-side recirculation");
        if (gh[2] !== 1'b0 || gl[2] !== 1'b0) begin
            errors++;
            $display("FAIL R11 leg2 hi=%b lo=%b expected 0 0", gh[2], gl[2]);
        end
        checks++;

        // R7 and R11: high-side recirculation
        mode = 1'b1;
        expect_model("R7 high-side recirculation, R11 off leg");

        // R5: direction swap with PWM on, then with low-side recirculation
        pwm = 1'b1;
        mode = 1'b0;
        dir = 1'b1;
        expect_model("R5 direction swap");
        pwm = 1'b0;
        expect_model("R5 swap with recirculation");

        // R8: bootstrap overrides everything
        dir = 1'b0;
        pwm = 1'b1;
        boot = 1'b1;
        expect_model("R8 bootstrap all low");
        mode = 1'b1;
        pwm = 1'b0;
        dir = 1'b1;
        expect_model("R8 bootstrap priority");
        boot = 1'b0;
        dir = 1'b0;
        pwm = 1'b1;
        mode = 1'b0;
        req = 6'b00_10_01;
        expect_model("R4 return to requests");

        // R9: coast is immediate, then a full dead count after release
        coast = 1'b1;
        #1;
        checks++;
        if (gh !== 3'b000 || gl !== 3'b000) begin
            errors++;
            $display("FAIL R9 immediate: hi=%b lo=%b expected 000 000", gh, gl);
        end
        step();
        expect_next(3'b000, 3'b000, "R9 coast held");
        coast = 1'b0;
        for (int k = 0; k < 4; k++) expect_next(3'b000, 3'b000, "R9 dead after coast");
        expect_next(3'b001, 3'b010, "R9 turn-on after coast");

        // R3: zero dead count acts as one cycle
        dead = '0;
        step();
        req = 6'b00_01_10;
        expect_next(3'b000, 3'b000, "R3 single dead cycle");
        expect_next(3'b010, 3'b001, "R3 turn-on after one cycle");

        // R2: longer dead count
        dead = 12'd7;
        step();
        req = 6'b00_10_01;
        for (int k = 0; k < 7; k++) expect_next(3'b000, 3'b000, "R2 dead interval D=7");
        expect_next(3'b001, 3'b010, "R2 turn-on after D=7");

        repeat (3) step();
        finish_run();
    end
endmodule